// File: doc/BRIEF.md
# Serial Power and Coefficient Link

This block measures the average power of a complex baseband stream and exchanges it with an external memory-effects processor over a four-wire serial link. Every clock carries one I/Q sample. The block sums I²+Q² over a window of 2^L samples, where L is a base exponent plus a 2-bit period code, and divides the sum by the window length with a right shift. The 32-bit unsigned result is sent during the following window as one serial frame. The serial bit rate comes from the window length, so one frame of 32 bits fills exactly one window.

The same frame carries two 16-bit compensation coefficients back in. The block drives the serial clock and the frame sync, and it samples the return data on the rising half of each bit. A full received frame updates both coefficients together and raises a one-cycle valid pulse. When the receive side is disabled, the coefficient outputs follow two host-supplied values.

A three-state controller sequences the block. ST_IDLE lasts one cycle after reset and latches the first period code (IDLE→FILL, always). ST_FILL integrates the first window with the link silent (FILL→RUN when the window's last sample is taken, FILL→FILL otherwise). ST_RUN transmits one frame per window and stays there (RUN→RUN). Reset forces any state to ST_IDLE.

Top module: `pwrlink_serial`

## Requirements
- R1: Each sample taken in ST_FILL or ST_RUN adds I²+Q² (I, Q two's complement) to the running sum of its window. The average for a window is that sum shifted right by L.
- R2: An average that does not fit in 32 bits is sent as 0xFFFFFFFF.
- R3: With a base exponent of 8, period codes 0, 1, 2 and 3 give windows of 256, 512, 1024 and 2048 samples. A new code takes effect at the next window boundary. Each frame, measured from one sync to the next, lasts exactly one window.
- R4: A frame has 32 bits, MSB first, and each bit lasts 2^(L-5) clocks. The serial clock is low for the first half of a bit and high for the second half. Data changes only while the serial clock is low.
- R5: The sync output is high for exactly one clock, in the first cycle of every frame, and is low at all other times.
- R6: While tx_en is low, ser_out stays 0. Serial clock and sync keep running.
- R7: With rx_en high for a whole frame, ser_in is sampled on each rising half of the serial clock. The first 16 bits form A (MSB first) and the last 16 form B (MSB first). Both are updated at the end of the frame, and coef_valid is high for one cycle, which is the cycle in which the next sync is high.
- R8: While rx_en is low, coef_a and coef_b take host_coef_a and host_coef_b one clock later, and coef_valid stays low.
- R9: In reset, all serial outputs, coef_valid and the coefficients are 0. After reset is released, one setup cycle is followed by a silent first window, so the first sync is seen 2^L+2 bench cycles after release.
- R10: The frame that starts at a sync carries the average of the window that ended at that sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | 18 | In-phase sample, two's complement |
| samp_q | input | 18 | Quadrature sample, two's complement |
| period_sel | input | 2 | Window length code (window = 2^(8+code)) |
| tx_en | input | 1 | Enables data on ser_out |
| rx_en | input | 1 | Takes coefficients from ser_in instead of host values |
| host_coef_a | input | 16 | Host value for coefficient A |
| host_coef_b | input | 16 | Host value for coefficient B |
| ser_in | input | 1 | Serial coefficient data from the external processor |
| ser_clk | output | 1 | Divided serial clock |
| ser_sync | output | 1 | One-cycle pulse marking the first bit of a frame |
| ser_out | output | 1 | Serial average-power data, MSB first |
| coef_a | output | 16 | Active coefficient A |
| coef_b | output | 16 | Active coefficient B |
| coef_valid | output | 1 | One-cycle pulse when a received pair is committed |

## Verification
A sample counter that is off by one shows up at the very next sync as a frame of the wrong length. The same error shifts the serial clock phase, so the decoded bits go wrong within one bit time. If the integrator picks up a wrong sample or shift, the error shows in the word received one frame later, because each window is reported during the next one. An armed flag or commit condition that is wrong shows at the end of the affected frame: coef_valid is missing or appears when it should not, or the coefficient outputs do not match what was sent or what the host supplies.

// File: rtl/pwrlink_pkg.sv
package pwrlink_pkg;

    // Frame geometry: the outgoing word and the incoming coefficient pair
    // both span this many bits.
    localparam int FRAME_BITS = 32;
    localparam int FRAME_LOG  = 5;
    localparam int COEF_W     = FRAME_BITS / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } link_state_t;

endpackage

// File: rtl/pwrlink_timer.sv
// Window and bit timing controller. BASE_LOG must be at least FRAME_LOG+1
// so that each serial bit spans at least two clocks.
module pwrlink_timer
    import pwrlink_pkg::*;
#(
    parameter int BASE_LOG = 8,
    parameter int SEL_W    = 2,
    localparam int MAX_LOG = BASE_LOG + (1 << SEL_W) - 1,
    localparam int CNT_W   = MAX_LOG,
    localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     period_sel,
    output logic                 run,
    output logic                 acc_en,
    output logic                 win_last,
    output logic                 frame_first,
    output logic                 rx_strobe,
    output logic                 sclk_lvl,
    output logic [FRAME_LOG-1:0] bit_idx,
    output logic [LOG_W-1:0]     win_log
);

    link_state_t         state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [LOG_W-1:0]    log_q;
    logic [CNT_W:0]      win_len;
    logic [CNT_W-1:0]    win_mask;
    logic [LOG_W-1:0]    bit_sh;
    logic [CNT_W-1:0]    bit_mask;
    logic [CNT_W-1:0]    half_pt;
    logic [CNT_W-1:0]    bit_pos;
    logic                at_last;

    // Derived window/bit geometry from the latched exponent
    always_comb begin
        win_len  = {{CNT_W{1'b0}}, 1'b1} << log_q;
        win_mask = win_len[CNT_W-1:0] - CNT_W'(1);
        bit_sh   = log_q - LOG_W'(FRAME_LOG);
        bit_mask = (CNT_W'(1) << bit_sh) - CNT_W'(1);
        half_pt  = CNT_W'(1) << (bit_sh - LOG_W'(1));
        bit_pos  = cnt_q & bit_mask;
        at_last  = (state_q != ST_IDLE) && (cnt_q == win_mask);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_FILL;
            ST_FILL: state_d = at_last ? ST_RUN : ST_FILL;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sample counter and period latch: the code is taken only at a boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            log_q <= LOG_W'(BASE_LOG);
        end else if (state_q == ST_IDLE || at_last) begin
            cnt_q <= '0;
            log_q <= LOG_W'(BASE_LOG) + LOG_W'(period_sel);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Per-state outputs
    always_comb begin
        run         = 1'b0;
        acc_en      = 1'b0;
        frame_first = 1'b0;
        rx_strobe   = 1'b0;
        sclk_lvl    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: acc_en = 1'b1;
            ST_RUN: begin
                run         = 1'b1;
                acc_en      = 1'b1;
                frame_first = (cnt_q == '0);
                rx_strobe   = (bit_pos == half_pt);
                sclk_lvl    = |(cnt_q & half_pt);
            end
            default: ;
        endcase
    end

    assign win_last = at_last;
    assign bit_idx  = FRAME_LOG'(cnt_q >> bit_sh);
    assign win_log  = log_q;

    AST_WIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> (cnt_q == '0)) else $error("window wrap"); // R3

endmodule

// File: rtl/pwrlink_integrator.sv
module pwrlink_integrator
    import pwrlink_pkg::*;
#(
    parameter int W       = 18,
    parameter int MAX_LOG = 11,
    parameter int LOG_W   = 4,
    localparam int PW_W   = 2 * W + 1,
    localparam int ACC_W  = PW_W + MAX_LOG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    win_last,
    input  logic [LOG_W-1:0]        win_log,
    input  logic signed [W-1:0]     samp_i,
    input  logic signed [W-1:0]     samp_q,
    output logic [FRAME_BITS-1:0]   avg_word
);

    logic signed [2*W-1:0] i_sq, q_sq;
    logic [PW_W-1:0]       pw;
    logic [ACC_W-1:0]      acc_q, total, shifted;
    logic                  over;

    always_comb begin
        i_sq    = samp_i * samp_i;
        q_sq    = samp_q * samp_q;
        pw      = PW_W'($unsigned(i_sq)) + PW_W'($unsigned(q_sq));
        total   = acc_q + ACC_W'(pw);
        shifted = total >> win_log;
        over    = |shifted[ACC_W-1:FRAME_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            avg_word <= '0;
        end else if (acc_en) begin
            if (win_last) begin
                acc_q    <= '0;
                avg_word <= over ? '1 : shifted[FRAME_BITS-1:0];
            end else begin
                acc_q <= total;
            end
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && win_last) |=> (acc_q == '0)) else $error("acc clear"); // R1

endmodule

// File: rtl/pwrlink_coef_rx.sv
module pwrlink_coef_rx
    import pwrlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rx_en,
    input  logic              frame_first,
    input  logic              rx_strobe,
    input  logic              win_last,
    input  logic              ser_in,
    input  logic [COEF_W-1:0] host_a,
    input  logic [COEF_W-1:0] host_b,
    output logic [COEF_W-1:0] coef_a,
    output logic [COEF_W-1:0] coef_b,
    output logic              coef_valid
);

    logic [FRAME_BITS-1:0] rx_sh;
    logic                  armed_q;
    logic                  commit;

    assign commit = run && win_last && armed_q && rx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            armed_q    <= 1'b0;
            coef_a     <= '0;
            coef_b     <= '0;
            coef_valid <= 1'b0;
        end else begin
            if (rx_strobe)   rx_sh   <= {rx_sh[FRAME_BITS-2:0], ser_in};
            if (frame_first) armed_q <= rx_en;
            coef_valid <= commit;
            if (commit) begin
                coef_a <= rx_sh[FRAME_BITS-1:COEF_W];
                coef_b <= rx_sh[COEF_W-1:0];
            end else if (!rx_en) begin
                coef_a <= host_a;
                coef_b <= host_b;
            end
        end
    end

    AST_HOST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && $past(!rx_en) && $past(rst_n)) |-> (coef_a == $past(host_a) && coef_b == $past(host_b)))
        else $error("host follow"); // R8

endmodule

// File: rtl/pwrlink_serial.sv
module pwrlink_serial
    import pwrlink_pkg::*;
#(
    parameter int W        = 18,
    parameter int BASE_LOG = 8,
    parameter int SEL_W    = 2,
    localparam int MAX_LOG = BASE_LOG + (1 << SEL_W) - 1,
    localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [W-1:0]     samp_i,
    input  logic signed [W-1:0]     samp_q,
    input  logic [SEL_W-1:0]        period_sel,
    input  logic                    tx_en,
    input  logic                    rx_en,
    input  logic [COEF_W-1:0]       host_coef_a,
    input  logic [COEF_W-1:0]       host_coef_b,
    input  logic                    ser_in,
    output logic                    ser_clk,
    output logic                    ser_sync,
    output logic                    ser_out,
    output logic [COEF_W-1:0]       coef_a,
    output logic [COEF_W-1:0]       coef_b,
    output logic                    coef_valid
);

    logic                  run, acc_en, win_last, frame_first, rx_strobe, sclk_lvl;
    logic [FRAME_LOG-1:0]  bit_idx;
    logic [LOG_W-1:0]      win_log;
    logic [FRAME_BITS-1:0] avg_word;

    pwrlink_timer #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .period_sel(period_sel),
        .run(run), .acc_en(acc_en), .win_last(win_last),
        .frame_first(frame_first), .rx_strobe(rx_strobe),
        .sclk_lvl(sclk_lvl), .bit_idx(bit_idx), .win_log(win_log)
    );

    pwrlink_integrator #(.W(W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .win_last(win_last),
        .win_log(win_log), .samp_i(samp_i), .samp_q(samp_q),
        .avg_word(avg_word)
    );

    pwrlink_coef_rx u_rx (
        .clk(clk), .rst_n(rst_n), .run(run), .rx_en(rx_en),
        .frame_first(frame_first), .rx_strobe(rx_strobe),
        .win_last(win_last), .ser_in(ser_in),
        .host_a(host_coef_a), .host_b(host_coef_b),
        .coef_a(coef_a), .coef_b(coef_b), .coef_valid(coef_valid)
    );

    // Word bits are indexed MSB first by the bit counter
    assign ser_clk  = sclk_lvl;
    assign ser_sync = frame_first;
    assign ser_out  = run && tx_en && avg_word[FRAME_LOG'(FRAME_BITS - 1) - bit_idx];

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sync |=> !ser_sync) else $error("sync width"); // R5
    AST_SYNC_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sync |-> !ser_clk) else $error("sync phase"); // R4
    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $stable(tx_en)) |-> $stable(ser_out)) else $error("data moved"); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |=> !coef_valid) else $error("valid width"); // R7
    AST_VALID_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> ser_sync) else $error("valid timing"); // R7

endmodule

// File: tb/test_pwrlink_serial.sv
module test_pwrlink_serial;
    localparam int W    = 18;
    localparam int BASE = 8;
    localparam int NFRM = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [W-1:0] samp_i = '0, samp_q = '0;
    logic [1:0]  period_sel = 2'd0;
    logic        tx_en = 1'b1, rx_en = 1'b0, ser_in = 1'b0;
    logic [15:0] host_a = 16'h1234, host_b = 16'h5678;
    logic        ser_clk, ser_sync, ser_out, coef_valid;
    logic [15:0] coef_a, coef_b;

    always #2 clk = ~clk;

    pwrlink_serial i_pwrlink_serial (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .samp_q(samp_q),
        .period_sel(period_sel), .tx_en(tx_en), .rx_en(rx_en),
        .host_coef_a(host_a), .host_coef_b(host_b), .ser_in(ser_in),
        .ser_clk(ser_clk), .ser_sync(ser_sync), .ser_out(ser_out),
        .coef_a(coef_a), .coef_b(coef_b), .coef_valid(coef_valid)
    );

    int n_tests = 0, n_fail = 0;
    bit started = 0, done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_avg(longint unsigned s, int l);
        longint unsigned a = s >> l;
        return (a > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : a[31:0];
    endfunction

    // Monitor and stimulus state
    int cyc = 0, frames = 0, cur_l = BASE, frame_l = BASE, frame_len = 0;
    int bit_cnt = 0, rx_idx = 0, mode = 2;
    longint unsigned acc_m = 0;
    logic [31:0] got_word = '0, exp_word = '0, rx_word = '0;
    bit frame_tx = 1, frame_rx = 0;
    logic prev_clk = 1'b0;

    always @(negedge clk) begin
        if (started && !done) begin
            cyc++;
            if (ser_clk && !prev_clk) begin
                got_word = {got_word[30:0], ser_out};
                bit_cnt++;
            end
            if (ser_sync) begin
                if (frames == 0) begin
                    chk(cyc == (1 << cur_l) + 2, "R9", "first sync cycle", cyc, (1 << cur_l) + 2);
                    chk(!coef_valid, "R8", "no valid before frames", coef_valid, 0);
                    chk({coef_a, coef_b} == {host_a, host_b}, "R8", "host coef", {coef_a, coef_b}, {host_a, host_b});
                end else begin
                    chk(bit_cnt == 32, "R4", "bits per frame", bit_cnt, 32);
                    chk(frame_len == (1 << frame_l), "R3", "frame length", frame_len, (1 << frame_l));
                    // R10: the decoded word is the average of the window before this frame
                    chk(got_word == exp_word,
                        !frame_tx ? "R6" : (exp_word == 32'hFFFF_FFFF ? "R2" : "R1/R10"),
                        "serial word", got_word, exp_word);
                    if (frame_rx)
                        chk(coef_valid && {coef_a, coef_b} == rx_word, "R7", "received pair",
                            {coef_valid, coef_a, coef_b}, {1'b1, rx_word});
                    else
                        chk(!coef_valid && {coef_a, coef_b} == {host_a, host_b}, "R8", "host pair",
                            {coef_valid, coef_a, coef_b}, {1'b0, host_a, host_b});
                end
                frames++;
                // Settings for the frame that starts now
                case (frames)
                    1: begin mode = 0; tx_en = 1; rx_en = 1; rx_word = 32'hA5C3_0F81; end
                    2: begin mode = 1; tx_en = 1; rx_en = 1; rx_word = 32'h8000_0001; end
                    3: begin mode = 4; tx_en = 0; rx_en = 0; end
                    4: begin mode = 3; tx_en = 1; rx_en = 1; rx_word = 32'hFFFF_0000; end
                    default: begin
                        mode    = int'($urandom % 5);
                        tx_en   = ($urandom % 5) != 0;
                        rx_en   = ($urandom % 4) != 0;
                        rx_word = $urandom;
                    end
                endcase
                exp_word = tx_en ? model_avg(acc_m, cur_l) : 32'h0;
                cur_l    = BASE + int'(period_sel);
                frame_l  = cur_l;
                // Next boundary picks up this code
                if (frames == 4)      period_sel = 2'd3;
                else if (frames == 5) period_sel = 2'd1;
                else if (frames > 5)  period_sel = 2'($urandom % 4);
                host_a    = 16'($urandom);
                host_b    = 16'($urandom);
                frame_tx  = tx_en;
                frame_rx  = rx_en;
                acc_m     = 0;
                bit_cnt   = 0;
                frame_len = 0;
                got_word  = '0;
                rx_idx    = 0;
                ser_in    = rx_word[31];
                if (frames == NFRM) done = 1;
            end else if (prev_clk && !ser_clk) begin
                rx_idx++;
                ser_in = (rx_idx < 32) ? rx_word[31 - rx_idx] : 1'b0;
            end
            // Sample for the next edge
            if (cyc < 2) begin
                samp_i = '0; samp_q = '0;
            end else begin
                case (mode)
                    0: begin samp_i = '0; samp_q = '0; end
                    1: begin samp_i = {1'b1, {(W-1){1'b0}}}; samp_q = {1'b1, {(W-1){1'b0}}}; end
                    2: begin samp_i = W'(int'($urandom % 8192) - 4096); samp_q = W'(int'($urandom % 8192) - 4096); end
                    3: begin samp_i = W'($urandom); samp_q = W'($urandom); end
                    default: begin samp_i = W'(int'($urandom % 65536) - 32768); samp_q = W'(int'($urandom % 65536) - 32768); end
                endcase
            end
            acc_m += longint'(samp_i) * longint'(samp_i) + longint'(samp_q) * longint'(samp_q);
            frame_len++;
            prev_clk = ser_clk;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5239);
        repeat (3) @(negedge clk);
        chk({ser_clk, ser_sync, ser_out, coef_valid} == 4'b0, "R9", "serial outputs in reset",
            {ser_clk, ser_sync, ser_out, coef_valid}, 0);
        chk({coef_a, coef_b} == 32'h0, "R9", "coefficients in reset", {coef_a, coef_b}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        started = 1;
        @(negedge clk);
        chk({ser_clk, ser_sync} == 2'b0, "R9", "quiet after release", {ser_clk, ser_sync}, 0);
        wait (done);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog: actual %0d frames expected %0d", frames, NFRM);
            done = 1;
        end
    end

endmodule